// File: doc/BRIEF.md
# Gate Descriptor Dispatcher

This block turns an interrupt vector number into a dispatch decision by reading an 8-byte gate descriptor from a table held in ordinary memory. The table can sit anywhere in the address space and can be shorter than the full vector range. Two software-visible registers describe it: a start address and a highest valid byte offset. Both can be loaded and read back through a small register port.

For each accepted vector the block does four things. It bounds-checks the descriptor against the table end. It reads the descriptor as four 16-bit words over a single-outstanding memory port. It assembles the handler selector and offset. It decodes the gate kind. The result is one of three outcomes:

- a handler target, together with a flag saying whether interrupts must be masked on entry;
- a request to switch to another task, carrying the target selector;
- a fault with a reason code.

A one-cycle strobe marks the result as valid.

Top module: `gate_dispatch`

## Requirements
- R1: After reset `done`, `busy` and `mem_req` are 0, and both table registers read back as 0.
- R2: A cycle with `tbl_wr`=1 loads the table start address (`tbl_sel`=0, full width) or the table end offset (`tbl_sel`=1, low LIM_W bits). `tbl_rdata` shows the register picked by `tbl_sel` in the same cycle, with the end offset zero-extended.
- R3: For vector n the descriptor starts at start + 8·n, modulo 2^ADDR_W. It is read as four 16-bit words at +0, +2, +4 and +6, in that order. `mem_addr` holds steady while `mem_req` is high without `mem_ack`.
- R4: If 8·n+7 is greater than the end offset, no memory read is issued. `done` rises one cycle after acceptance with fault code 1.
- R5: The handler offset is {word at +6, word at +0}. The selector is the word at +2.
- R6: The control byte is the high byte of the word at +4. Bit 7 of that byte is the present bit and bits 6:0 are the kind. Kind 0x0E is an interrupt gate and sets `clr_if`=1. Kind 0x0F is a trap gate and gives `clr_if`=0. Kind 0x05 is a task gate: it sets `task_req`=1, reports the selector and forces the offset to 0.
- R7: A clear present bit gives fault code 2, and this takes priority over the kind check. A present descriptor with any other kind gives code 3. A fault reports `fault`=1 with selector, offset, `clr_if` and `task_req` all 0. Code 0 means no fault.
- R8: `done` is high for exactly one cycle, one cycle after the fourth read is acknowledged. `busy` stays high from acceptance through the `done` cycle. A `vec_valid` seen while `busy` is high is ignored and produces no further dispatch.
- R9: The result outputs change only in the cycle `done` is high, and hold their value until the next `done`.
- R10: The start address and end offset are sampled at acceptance. Loading a register during a fetch does not change that fetch's addresses or bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbl_wr | input | 1 | Load strobe for a table register |
| tbl_sel | input | 1 | 0 = table start, 1 = table end offset |
| tbl_wdata | input | ADDR_W | Load value |
| tbl_rdata | output | ADDR_W | Readback of the selected register |
| vec_valid | input | 1 | Vector request |
| vec_num | input | VEC_W | Vector number |
| busy | output | 1 | A dispatch is in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the 16-bit word |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | Result valid strobe |
| fault | output | 1 | Dispatch faulted |
| fault_code | output | 2 | 0 none, 1 bound, 2 not present, 3 bad kind |
| clr_if | output | 1 | Interrupt-enable flag must be cleared |
| task_req | output | 1 | Task switch requested |
| out_sel | output | 16 | Handler or task selector |
| out_off | output | 32 | Handler offset |

## Verification
A wrong fetch index or latched address shows up on `mem_addr` at the very next acknowledged read, because the bench logs every address and compares it with start + 8·n + 2k. A field assembled from the wrong word, or a kind decoded wrongly, shows up in the one cycle `done` is high. A wrong bound comparison shows up either as a memory request where none was due, or as `done` arriving one cycle after acceptance when four reads were expected. A stuck or repeated done state shows up the cycle after `done`, either as a second strobe or as `busy` still high.

// File: rtl/gd_pkg.sv
`timescale 1ns/1ps
package gd_pkg;
    localparam int WORD_W = 16;
    localparam int OFF_W  = 2 * WORD_W;

    localparam logic [6:0] KIND_INTR = 7'h0E;
    localparam logic [6:0] KIND_TRAP = 7'h0F;
    localparam logic [6:0] KIND_TASK = 7'h05;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_BOUND  = 2'd1,
        FLT_ABSENT = 2'd2,
        FLT_KIND   = 2'd3
    } flt_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } st_e;

    typedef struct packed {
        logic [WORD_W-1:0] sel;
        logic [OFF_W-1:0]  off;
        logic              clr_if;
        logic              task_req;
        flt_e              code;
    } result_t;
endpackage

// File: rtl/gd_tblregs.sv
`timescale 1ns/1ps
module gd_tblregs #(
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output logic [ADDR_W-1:0] base_o,
    output logic [LIM_W-1:0]  limit_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d = q;
        if (wr) begin
            if (sel) d.limit = wdata[LIM_W-1:0];
            else     d.base  = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign base_o  = q.base;
    assign limit_o = q.limit;
    assign rdata   = sel ? ADDR_W'(q.limit) : q.base;

    // R2
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !sel |=> base_o == $past(wdata));
    // R2
    limit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && sel |=> limit_o == $past(wdata[LIM_W-1:0]));
endmodule

// File: rtl/gd_bound.sv
`timescale 1ns/1ps
module gd_bound #(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 8,
    parameter int LIM_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] addr,
    output logic              over
);
    localparam int SPAN_W = VEC_W + 3;
    localparam int CMP_W  = (LIM_W > SPAN_W) ? LIM_W : SPAN_W;

    logic [SPAN_W-1:0] first_b;
    logic [SPAN_W-1:0] last_b;

    always_comb begin
        first_b = {vec, 3'b000};
        last_b  = {vec, 3'b111};
        addr    = base + ADDR_W'(first_b);
        over    = CMP_W'(last_b) > CMP_W'(limit);
    end
endmodule

// File: rtl/gd_gate_decode.sv
`timescale 1ns/1ps
module gd_gate_decode
    import gd_pkg::*;
(
    input  logic [WORD_W-1:0] w_off_lo,
    input  logic [WORD_W-1:0] w_sel,
    input  logic [7:0]        ctrl,
    input  logic [WORD_W-1:0] w_off_hi,
    output result_t           res
);
    logic       present;
    logic [6:0] kind;

    always_comb begin
        present = ctrl[7];
        kind    = ctrl[6:0];
        res     = '0;
        if (!present) begin
            res.code = FLT_ABSENT;
        end else begin
            case (kind)
                KIND_INTR: begin
                    res.sel    = w_sel;
                    res.off    = {w_off_hi, w_off_lo};
                    res.clr_if = 1'b1;
                end
                KIND_TRAP: begin
                    res.sel = w_sel;
                    res.off = {w_off_hi, w_off_lo};
                end
                KIND_TASK: begin
                    res.sel      = w_sel;
                    res.task_req = 1'b1;
                end
                default: res.code = FLT_KIND;
            endcase
        end
    end
endmodule

// File: rtl/gate_dispatch.sv
`timescale 1ns/1ps
module gate_dispatch
    import gd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 8,
    parameter int LIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr,
    input  logic              tbl_sel,
    input  logic [ADDR_W-1:0] tbl_wdata,
    output logic [ADDR_W-1:0] tbl_rdata,
    input  logic              vec_valid,
    input  logic [VEC_W-1:0]  vec_num,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_code,
    output logic              clr_if,
    output logic              task_req,
    output logic [15:0]       out_sel,
    output logic [31:0]       out_off
);
    localparam int IDX_W = 2;

    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] w_off_lo;
        logic [WORD_W-1:0] w_sel;
        logic [7:0]        ctrl;
        result_t           res;
        logic              done;
    } ctl_t;

    ctl_t d, q;

    logic [ADDR_W-1:0] base_w;
    logic [LIM_W-1:0]  limit_w;
    logic [ADDR_W-1:0] desc_addr;
    logic              over;
    result_t           dec_res;

    gd_tblregs #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(tbl_wr), .sel(tbl_sel),
        .wdata(tbl_wdata), .rdata(tbl_rdata),
        .base_o(base_w), .limit_o(limit_w)
    );

    gd_bound #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .LIM_W(LIM_W)) u_bound (
        .base(base_w), .limit(limit_w), .vec(vec_num),
        .addr(desc_addr), .over(over)
    );

    gd_gate_decode u_dec (
        .w_off_lo(q.w_off_lo), .w_sel(q.w_sel), .ctrl(q.ctrl),
        .w_off_hi(mem_rdata), .res(dec_res)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (vec_valid && !q.done) begin
                    if (over) begin
                        d.res      = '0;
                        d.res.code = FLT_BOUND;
                        d.done     = 1'b1;
                    end else begin
                        d.st   = ST_FETCH;
                        d.addr = desc_addr;
                        d.idx  = '0;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    d.idx = q.idx + 1'b1;
                    case (q.idx)
                        2'd0: d.w_off_lo = mem_rdata;
                        2'd1: d.w_sel    = mem_rdata;
                        2'd2: d.ctrl     = mem_rdata[15:8];
                        default: begin
                            d.res  = dec_res;
                            d.done = 1'b1;
                            d.st   = ST_IDLE;
                        end
                    endcase
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy       = (q.st != ST_IDLE) || q.done;
    assign mem_req    = (q.st == ST_FETCH);
    assign mem_addr   = q.addr + ADDR_W'({q.idx, 1'b0});
    assign done       = q.done;
    assign fault_code = q.res.code;
    assign fault      = (q.res.code != FLT_NONE);
    assign clr_if     = q.res.clr_if;
    assign task_req   = q.res.task_req;
    assign out_sel    = q.res.sel;
    assign out_off    = q.res.off;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
    // R4
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
    // R6
    gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(clr_if && task_req));
    // R7
    fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> !clr_if && !task_req && out_sel == '0 && out_off == '0);
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_off) || !$stable(out_sel) || !$stable(fault_code) |-> done);
endmodule

// File: tb/gate_dispatch_bench.sv
`timescale 1ns/1ps
module gate_dispatch_bench;
    localparam int ADDR_W = 32;
    localparam int VEC_W  = 8;
    localparam int LIM_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tbl_wr = 1'b0;
    logic              tbl_sel = 1'b0;
    logic [ADDR_W-1:0] tbl_wdata = '0;
    logic [ADDR_W-1:0] tbl_rdata;
    logic              vec_valid = 1'b0;
    logic [VEC_W-1:0]  vec_num = '0;
    logic              busy, mem_req, done, fault, clr_if, task_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ack = 1'b0;
    logic [15:0]       mem_rdata = '0;
    logic [1:0]        fault_code;
    logic [15:0]       out_sel;
    logic [31:0]       out_off;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int unsigned done_cnt = 0;
    int unsigned n_acks = 0;
    logic [ADDR_W-1:0] addr_log [8];
    logic [7:0]  cur_ctrl = 8'h8E;
    logic [ADDR_W-1:0] sh_base = '0;
    logic [LIM_W-1:0]  sh_limit = '0;
    logic        finished = 1'b0;

    logic [1:0]  e_code;
    logic [15:0] e_sel;
    logic [31:0] e_off;
    logic        e_clr, e_task;
    logic [ADDR_W-1:0] e_addr;

    gate_dispatch #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .LIM_W(LIM_W)) u_gate_dispatch (
        .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_sel(tbl_sel),
        .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata), .vec_valid(vec_valid),
        .vec_num(vec_num), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .fault_code(fault_code), .clr_if(clr_if), .task_req(task_req),
        .out_sel(out_sel), .out_off(out_off)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] hash16(logic [31:0] a);
        logic [31:0] t;
        t = (a * 32'h9E37_79B1) ^ 32'h1357_2468;
        return t[31:16] ^ t[15:0];
    endfunction

    function automatic logic [15:0] mem_word(logic [31:0] a);
        logic [15:0] h;
        h = hash16(a);
        if (a[2:0] == 3'd4) return {cur_ctrl, h[7:0]};
        return h;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Memory responder: one-cycle acks after 0..2 wait cycles
    initial begin : responder
        int unsigned wait_left;
        wait_left = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack   = 1'b0;
                wait_left = $urandom % 3;
            end else if (mem_req) begin
                if (wait_left == 0) begin
                    mem_ack   = 1'b1;
                    mem_rdata = mem_word(mem_addr);
                    if (n_acks < 8) addr_log[n_acks] = mem_addr;
                    n_acks++;
                end else begin
                    wait_left--;
                end
            end
        end
    end

    initial begin : done_mon
        forever begin
            @(negedge clk);
            if (done) done_cnt++;
        end
    end

    task automatic tbl_write(logic sel, logic [ADDR_W-1:0] v);
        @(negedge clk);
        tbl_wr = 1'b1; tbl_sel = sel; tbl_wdata = v;
        @(negedge clk);
        tbl_wr = 1'b0;
        if (sel) sh_limit = v[LIM_W-1:0];
        else     sh_base  = v;
    endtask

    task automatic expect_calc(logic [VEC_W-1:0] v);
        logic [31:0] last;
        last   = {21'd0, v, 3'b111};
        e_addr = sh_base + {21'd0, v, 3'b000};
        e_code = 2'd0; e_sel = '0; e_off = '0; e_clr = 1'b0; e_task = 1'b0;
        if (last > {16'd0, sh_limit}) e_code = 2'd1;
        else if (!cur_ctrl[7]) e_code = 2'd2;
        else if (cur_ctrl[6:0] == 7'h0E) begin
            e_sel = mem_word(e_addr + 2);
            e_off = {mem_word(e_addr + 6), mem_word(e_addr)};
            e_clr = 1'b1;
        end else if (cur_ctrl[6:0] == 7'h0F) begin
            e_sel = mem_word(e_addr + 2);
            e_off = {mem_word(e_addr + 6), mem_word(e_addr)};
        end else if (cur_ctrl[6:0] == 7'h05) begin
            e_sel  = mem_word(e_addr + 2);
            e_task = 1'b1;
        end else e_code = 2'd3;
    endtask

    // mid: 1 = inject a busy-time request and a table load during the fetch
    task automatic dispatch(logic [VEC_W-1:0] v, logic [7:0] ctrl, bit mid);
        int cyc;
        int unsigned dc0;
        cur_ctrl = ctrl;
        expect_calc(v);
        n_acks = 0;
        @(negedge clk);
        vec_valid = 1'b1; vec_num = v;
        @(negedge clk);
        vec_valid = 1'b0;
        dc0 = done_cnt;
        cyc = 0;
        while (!done && cyc < 200) begin
            if (mid && cyc == 1) begin
                vec_valid = 1'b1; vec_num = 8'd200;
                tbl_wr = 1'b1; tbl_sel = 1'b0; tbl_wdata = 32'h5555_0000;
            end else if (mid && cyc == 2) begin
                vec_valid = 1'b0; tbl_wr = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 200) chk("R8 done timeout", 0, 1);
        chk("R5/R6 selector", out_sel, e_sel);
        chk("R5/R6 offset", out_off, e_off);
        chk("R6 clr_if", clr_if, e_clr);
        chk("R6 task_req", task_req, e_task);
        chk("R7 fault code", fault_code, e_code);
        chk("R7 fault flag", fault, e_code != 0);
        if (e_code == 2'd1) begin
            chk("R4 no reads on bound fault", n_acks, 0);
            chk("R4 done one cycle after accept", cyc, 0);
        end else begin
            chk("R3 read count", n_acks, 4);
            for (int k = 0; k < 4; k++)
                chk("R3 read address", addr_log[k], e_addr + 32'(2 * k));
        end
        @(negedge clk);
        chk("R8 done single cycle", done, 0);
        chk("R8 busy released", busy, 0);
        if (mid) begin
            repeat (6) @(negedge clk);
            chk("R8 request during busy ignored", done_cnt - dc0, 1);
            chk("R10 load landed after dispatch", tbl_rdata, 32'h5555_0000);
            sh_base = 32'h5555_0000;
        end
    endtask

    initial begin : watchdog
        #1_000_000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd24680);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", done, 0);
        chk("R1 busy", busy, 0);
        chk("R1 mem_req", mem_req, 0);
        tbl_sel = 1'b0; #1;
        chk("R1 base readback", tbl_rdata, 0);
        tbl_sel = 1'b1; #1;
        chk("R1 limit readback", tbl_rdata, 0);

        // R2 loads and readback
        tbl_write(1'b0, 32'h0001_0000);
        tbl_write(1'b1, 32'hABCD_00FF);
        tbl_sel = 1'b0; #1;
        chk("R2 base readback", tbl_rdata, 32'h0001_0000);
        tbl_sel = 1'b1; #1;
        chk("R2 limit zero-extended", tbl_rdata, 32'h0000_00FF);

        dispatch(8'd31, 8'h8E, 0);   // R4 last in-bound vector, interrupt gate
        dispatch(8'd32, 8'h8E, 0);   // R4 first out-of-bound vector
        dispatch(8'd3,  8'h8F, 0);   // R6 trap gate
        dispatch(8'd4,  8'h85, 0);   // R6 task gate
        dispatch(8'd5,  8'h0E, 0);   // R7 not present
        dispatch(8'd6,  8'h0C, 0);   // R7 absent wins over bad kind
        dispatch(8'd7,  8'h8C, 0);   // R7 bad kind
        dispatch(8'd8,  8'hCE, 0);   // R7 upper kind bits set

        // R9 hold after done
        dispatch(8'd9, 8'h8E, 0);
        repeat (5) @(negedge clk);
        chk("R9 offset held", out_off, e_off);
        chk("R9 selector held", out_sel, e_sel);

        // R3 address wrap
        tbl_write(1'b0, 32'hFFFF_FFF8);
        dispatch(8'd1, 8'h8F, 0);

        // R8 and R10 during a fetch
        tbl_write(1'b0, 32'h0002_0000);
        dispatch(8'd10, 8'h8E, 1);

        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [7:0] c;
            if (i % 8 == 0) tbl_write(1'b0, $urandom & 32'hFFFF_FFF8);
            if (i % 12 == 0) tbl_write(1'b1, (($urandom % 48) * 8) + 7);
            case ($urandom % 5)
                0: c = 8'h8E;
                1: c = 8'h8F;
                2: c = 8'h85;
                3: c = 8'h0F;
                default: c = 8'($urandom);
            endcase
            dispatch(8'($urandom % 56), c, 0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule